// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Group

This block is the interrupt register group of a peripheral. It keeps one pending flag for each hardware event source and one enable bit for each source, and it raises a single interrupt request while any source is both pending and enabled. Each event input pulse latches its flag. The flag stays set until software clears it by writing a one to that bit of the status register.

The enable mask has no plain writable register. Software changes it only through two strobe registers. Writing a one to a bit of the set register turns that enable on. Writing a one to a bit of the clear register turns it off. Bits written as zero leave their enables alone, so one source can be enabled or disabled without a read-modify-write. Either strobe register reads back the current mask.

The register bus is a simple one. A write takes effect on the next clock edge. A read returns data combinationally from the current address. The register offsets are bytes: status at 0x0, enable-set at 0x4 and enable-clear at 0x8. Every other offset is unmapped.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset all flags and all enables are zero and `irq_o` is low.
- R2: An event input held high at a clock edge sets the matching flag at that edge. A flag whose event is low keeps its value unless a clear hits it.
- R3: A write to offset 0x0 clears every flag whose data bit is one and leaves the flags whose data bit is zero unchanged. A read of offset 0x0 returns the flags in bits [NUM_SRC-1:0].
- R4: When an event and a status clear hit the same flag at the same edge, the flag is set after that edge.
- R5: A write to offset 0x4 sets every enable whose data bit is one and leaves the other enables unchanged.
- R6: A write to offset 0x8 clears every enable whose data bit is one and leaves the other enables unchanged.
- R7: A read of offset 0x4 or 0x8 returns the enable mask in bits [NUM_SRC-1:0]. Data bits at NUM_SRC and above always read as zero.
- R8: `irq_o` is high exactly when the bitwise AND of the flags and the enables is nonzero.
- R9: A flag is set by its event while its enable is off, and `irq_o` rises right after a later enable write to that bit.
- R10: A write to an unmapped offset changes no flag and no enable, and a read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Hardware event per source, one bit per source, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives an event and a status clear on the same bit at the same edge. A design that let the clear win would drop that event and show a zero flag. It sets a flag while its enable is off and then enables it. A design that gated the flag with its enable would never raise the request. Set and clear writes carry mixed data patterns, so a design that loaded the data into the mask, instead of using it as a mask of bits to change, would corrupt the bits written as zero. The bench also writes all-ones to unmapped and misaligned offsets and reads them. A loose address decode would then change the state or return nonzero data.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int OFF_STATUS = 'h0;
    localparam int OFF_EN_SET = 'h4;
    localparam int OFF_EN_CLR = 'h8;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_stb && clr_mask[i]) st_d.flags[i] = 1'b0;
            if (evt_i[i])               st_d.flags[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((st_q.flags & $past(evt_i)) == $past(evt_i))); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & ~$past(st_q.flags) & ~$past(evt_i)) == '0)); // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((st_q.flags & $past(clr_mask & ~evt_i)) == '0)); // R3
endmodule

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] en_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) st_d.en = st_q.en | bits_i;
        if (clr_stb) st_d.en = st_d.en & ~bits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((st_q.en & $past(bits_i)) == $past(bits_i))); // R5
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((st_q.en & $past(bits_i)) == '0)); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(st_q.en)); // R10
    AST_ZERO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.en & ~$past(bits_i)) == ($past(st_q.en) & ~$past(bits_i)))); // R5
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               stat_clr_stb,
    output logic               en_set_stb,
    output logic               en_clr_stb,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);

    logic hit_stat, hit_set, hit_clr;

    always_comb begin
        hit_stat = (bus_addr == A_STATUS);
        hit_set  = (bus_addr == A_EN_SET);
        hit_clr  = (bus_addr == A_EN_CLR);
        stat_clr_stb = bus_wr && hit_stat;
        en_set_stb   = bus_wr && hit_set;
        en_clr_stb   = bus_wr && hit_clr;
        rdata_o = '0;
        if (hit_stat)               rdata_o[NUM_SRC-1:0] = flags_i;
        else if (hit_set || hit_clr) rdata_o[NUM_SRC-1:0] = en_i;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_clr_stb, en_set_stb, en_clr_stb})); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_STATUS && bus_addr != A_EN_SET && bus_addr != A_EN_CLR)
        |-> (rdata_o == '0)); // R10
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] flags, en;
    logic               stat_clr_stb, en_set_stb, en_clr_stb;

    irq_reg_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .flags_i(flags), .en_i(en),
        .stat_clr_stb(stat_clr_stb), .en_set_stb(en_set_stb), .en_clr_stb(en_clr_stb),
        .rdata_o(bus_rdata)
    );

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .clr_stb(stat_clr_stb), .clr_mask(bus_wdata[NUM_SRC-1:0]),
        .flags_o(flags)
    );

    irq_enable_mask #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_stb(en_set_stb), .clr_stb(en_clr_stb),
        .bits_i(bus_wdata[NUM_SRC-1:0]), .en_o(en)
    );

    assign irq_o = |(flags & en);

    AST_REQ_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_stb && ((flags | evt_i) & bus_wdata[NUM_SRC-1:0]) != '0) |=> irq_o); // R9
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o); // R8
endmodule

// File: tb/irq_flag_unit_bench.sv
module irq_flag_unit_bench;
    localparam int N  = 8;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_i = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0] m_flags = '0;
    logic [N-1:0] m_en = '0;

    always #5 clk = ~clk;

    irq_flag_unit #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u_irq_flag_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
                                               input logic [N-1:0] fl,
                                               input logic [N-1:0] en);
        logic [DW-1:0] r;
        r = '0;
        if (a == 4'h0) r[N-1:0] = fl;
        else if (a == 4'h4 || a == 4'h8) r[N-1:0] = en;
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with given inputs, starting and ending near a falling edge; model updates at the edge.
    task automatic cycle(input logic [N-1:0] ev, input logic wr,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        evt_i = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (wr && a == 4'h0) m_flags = m_flags & ~d[N-1:0];
        if (wr && a == 4'h4) m_en = m_en | d[N-1:0];
        if (wr && a == 4'h8) m_en = m_en & ~d[N-1:0];
        m_flags = m_flags | ev;
        @(negedge clk);
        evt_i = '0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a, m_flags, m_en));
    endtask

    task automatic chk_all(input string req);
        read_chk({req, " status"}, 4'h0);
        read_chk({req, " en_set"}, 4'h4);
        read_chk({req, " en_clr"}, 4'h8);
        check({req, " R8 irq"}, DW'(irq_o), DW'(|(m_flags & m_en)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", DW'(irq_o), '0);
        read_chk("R1 status", 4'h0);
        read_chk("R1 mask", 4'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: flag latched while disabled, enable later raises request
        cycle(8'h04, 1'b0, 4'h0, '0);
        check("R9 irq low while disabled", DW'(irq_o), '0);
        read_chk("R9 R2 flag latched", 4'h0);
        cycle('0, 1'b1, 4'h4, 32'h0000_0004);
        check("R9 irq after enable", DW'(irq_o), 32'd1);

        // R4: event and clear on same bit at same edge
        cycle(8'h04, 1'b1, 4'h0, 32'h0000_00FF);
        read_chk("R4 event beats clear", 4'h0);
        check("R4 irq", DW'(irq_o), 32'd1);
        cycle('0, 1'b1, 4'h0, 32'h0000_0004);
        read_chk("R3 clear by one", 4'h0);

        // R5/R6 mixed patterns, R7 upper bits zero
        cycle('0, 1'b1, 4'h4, 32'hFFFF_FF5A);
        read_chk("R5 R7 set", 4'h4);
        cycle('0, 1'b1, 4'h8, 32'h0000_0012);
        read_chk("R6 R7 clr", 4'h8);
        cycle('0, 1'b1, 4'h4, 32'h0000_0000);
        read_chk("R5 zeros no effect", 4'h4);

        // R10 unmapped and misaligned offsets
        cycle(8'h81, 1'b0, 4'h0, '0);
        cycle('0, 1'b1, 4'hC, 32'hFFFF_FFFF);
        chk_all("R10 write 0xC");
        cycle('0, 1'b1, 4'h1, 32'hFFFF_FFFF);
        chk_all("R10 write 0x1");
        bus_addr = 4'hC; #1; check("R10 read 0xC", bus_rdata, '0);
        bus_addr = 4'h5; #1; check("R10 read 0x5", bus_rdata, '0);
        @(negedge clk);

        // Random mix of events and writes, R2 R3 R5 R6 R8
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0]  ev;
            logic          wr;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            ev = N'($urandom & $urandom & $urandom);
            wr = 1'($urandom % 2);
            case ($urandom % 5)
                0, 1: a = 4'h0;
                2:    a = 4'h4;
                3:    a = 4'h8;
                default: a = AW'($urandom);
            endcase
            d = $urandom;
            cycle(ev, wr, a, d);
            chk_all("R2 R3 R5 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule